// File: doc/BRIEF.md
# Data-Pattern-Aware RESET Timing Controller

This block chooses how long each RESET pulse lasts in one bitline-sharing set of a crossbar resistive memory. The pulse length depends on two things. The first is the worst-case share of low-resistance cells on the set's bitlines. The second is how far the addressed row sits from the write driver. A denser bitline and a more distant row both need a longer pulse, because sneak current lowers the voltage that reaches the cell.

The density estimate comes from a periodic profiling pass. After a start strobe, one digitized 3-bit density code arrives per mat. The block reduces these codes to their maximum and loads that maximum into a 3-bit worst-case level. Between passes, a 6-bit write counter raises the level by one step each time it wraps. This keeps the estimate safe while new data is being written.

For each accepted write, the level and the row group pick an entry from a fixed 8x8 nanosecond table. The entry is converted to clock cycles, rounded up. The block holds `busy` for exactly that many cycles and then pulses `done`.

Top module: `reset_timing_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are low, `pulse_cycles` is 0, the worst-case level is 000 and the write counter is 0.
- R2: A pass begins when `prof_start` is sampled high. It consumes one code per cycle in which `prof_valid` is high, and a valid in the same cycle as the start is dropped. After the 64th code, the level is loaded with the maximum of the 64 codes.
- R3: Until the pass completes, writes use the previous level. A `prof_valid` with no pass open has no effect.
- R4: The row group is `wr_row[8:6]`, where group 0 is farthest from the driver. The pulse length is ceil(T(level, group) * 1000 / CLK_PS) cycles. T is the latency table in ns. Level 000, groups 0..7: 109.7 106.9 99.7 90.8 81.8 73.2 64.5 56.4. Level 001: 132.9 129.3 120.9 107.9 93.9 81.3 69.2 58.8. Level 010: 154.6 150.9 140.9 126.0 107.9 90.3 74.7 60.9. Level 011: 173.8 169.7 158.5 142.0 121.9 99.8 80.2 63.4. Level 100: 189.0 184.3 172.6 154.8 132.9 109.0 85.8 65.5. Level 101: 199.0 194.0 181.8 162.9 139.8 115.0 90.5 68.0. Levels 110 and 111: 202.4 197.7 184.9 165.9 142.3 117.2 92.4 69.1.
- R5: Each accepted write increments the write counter. On the 64th write after a reload, the counter wraps and the level rises by one. That wrapping write still uses the old level. A completed pass clears the counter, and on a cycle where both happen the reload takes priority.
- R6: The level saturates at 111. A counter wrap at 111 leaves it at 111.
- R7: A write is accepted when `wr_req` is high at a clock edge while `busy` is low. From that edge `busy` is high for exactly N cycles, where N is the length from R4, and `pulse_cycles` shows N. `done` is then high for one cycle, with `busy` low.
- R8: A `wr_req` while `busy` is high is ignored. It does not change the pulse and does not advance the write counter.
- R9: A `prof_start` during an open pass discards the partial maximum and the partial code count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prof_start | input | 1 | Opens, or restarts, a profiling pass |
| prof_valid | input | 1 | `prof_code` carries one mat's density code |
| prof_code | input | 3 | Digitized density code of one mat |
| wr_req | input | 1 | Write request |
| wr_row | input | ROW_W (9) | Row address of the write |
| busy | output | 1 | RESET pulse in progress |
| done | output | 1 | One-cycle end-of-pulse strobe |
| pulse_cycles | output | CYC_W (8) | Length in cycles of the current or last pulse |

## Verification
The hardest states to reach from the ports are the ones hidden in the write counter. These include the 64th write that wraps the counter while still using the old level, the clearing of the counter by a reload, and saturation at the top level. None of these is visible until another 64 writes have gone by. The bench sets an exact level with a controlled profiling pass. It then issues runs of 64 and 65 writes and checks the pulse length of every one. This pins down which write sees the step. Repeating the runs with a request injected during each busy window shows that ignored requests do not advance the hidden counter.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
   localparam int LVL_W   = 3;
   localparam int GRP_W   = 3;
   localparam int NUM_GRP = 1 << GRP_W;
   localparam int unsigned TOP_TENTHS = 2024;

   // latency in tenths of a nanosecond, by level and row group
   function automatic int unsigned lat_tenth_ns(logic [LVL_W-1:0] lvl, logic [GRP_W-1:0] grp);
      int unsigned row [NUM_GRP];
      case (lvl)
         3'd0: row = '{1097, 1069,  997,  908,  818,  732,  645,  564};
         3'd1: row = '{1329, 1293, 1209, 1079,  939,  813,  692,  588};
         3'd2: row = '{1546, 1509, 1409, 1260, 1079,  903,  747,  609};
         3'd3: row = '{1738, 1697, 1585, 1420, 1219,  998,  802,  634};
         3'd4: row = '{1890, 1843, 1726, 1548, 1329, 1090,  858,  655};
         3'd5: row = '{1990, 1940, 1818, 1629, 1398, 1150,  905,  680};
         default: row = '{2024, 1977, 1849, 1659, 1423, 1172, 924, 691};
      endcase
      return row[grp];
   endfunction

   // ceiling conversion from tenths of ns to cycles of clk_ps picoseconds
   function automatic int unsigned to_cycles(int unsigned tenths, int unsigned clk_ps);
      return (tenths * 100 + clk_ps - 1) / clk_ps;
   endfunction
endpackage

// File: rtl/rtc_profiler.sv
`timescale 1ns/1ps
module rtc_profiler #(
   parameter int NUM_MATS = 64,
   parameter int CODE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output logic              load,
   output logic [CODE_W-1:0] max_code
);
   localparam int CNT_W = $clog2(NUM_MATS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_MATS - 1);

   logic              open_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] run_q;
   logic [CODE_W-1:0] run_nx;

   assign run_nx = (code > run_q) ? code : run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         cnt_q    <= '0;
         run_q    <= '0;
         load     <= 1'b0;
         max_code <= '0;
      end else begin
         load <= 1'b0;
         if (start) begin
            open_q <= 1'b1;
            cnt_q  <= '0;
            run_q  <= '0;
         end else if (open_q && valid) begin
            if (cnt_q == LAST) begin
               open_q   <= 1'b0;
               load     <= 1'b1;
               max_code <= run_nx;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               run_q <= run_nx;
            end
         end
      end
   end
endmodule

// File: rtl/rtc_level_ager.sv
`timescale 1ns/1ps
module rtc_level_ager #(
   parameter int LVL_W = 3,
   parameter int AGE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LVL_W-1:0] load_val,
   input  logic             wr_accept,
   output logic [LVL_W-1:0] level
);
   localparam logic [LVL_W-1:0] LVL_TOP = '1;

   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
         age_q <= '0;
      end else if (load) begin
         level <= load_val;
         age_q <= '0;
      end else if (wr_accept) begin
         age_q <= age_q + 1'b1;
         if ((&age_q) && (level != LVL_TOP))
            level <= level + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_lat_lookup.sv
`timescale 1ns/1ps
module rtc_lat_lookup #(
   parameter int unsigned CLK_PS = 8000,
   parameter int          CYC_W  = 8
) (
   input  logic [rtc_pkg::LVL_W-1:0] level,
   input  logic [rtc_pkg::GRP_W-1:0] group,
   output logic [CYC_W-1:0]          cycles
);
   logic [CYC_W-1:0] row_cyc [rtc_pkg::NUM_GRP];

   for (genvar g = 0; g < rtc_pkg::NUM_GRP; g++) begin : g_col
      assign row_cyc[g] = CYC_W'(rtc_pkg::to_cycles(
                             rtc_pkg::lat_tenth_ns(level, rtc_pkg::GRP_W'(g)), CLK_PS));
   end

   assign cycles = row_cyc[group];
endmodule

// File: rtl/rtc_pulse_timer.sv
`timescale 1ns/1ps
module rtc_pulse_timer #(
   parameter int CYC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CYC_W-1:0] len,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic [CYC_W-1:0] len_q
);
   logic [CYC_W-1:0] left_q;

   assign accept = req && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         left_q <= '0;
         len_q  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy   <= 1'b1;
            left_q <= len;
            len_q  <= len;
         end else if (busy) begin
            if (left_q <= 1) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/reset_timing_ctrl.sv
`timescale 1ns/1ps
module reset_timing_ctrl #(
   parameter int          NUM_MATS = 64,
   parameter int          ROW_W    = 9,
   parameter int          AGE_W    = 6,
   parameter int unsigned CLK_PS   = 8000,
   parameter int          CYC_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        prof_start,
   input  logic                        prof_valid,
   input  logic [rtc_pkg::LVL_W-1:0]   prof_code,
   input  logic                        wr_req,
   input  logic [ROW_W-1:0]            wr_row,
   output logic                        busy,
   output logic                        done,
   output logic [CYC_W-1:0]            pulse_cycles
);
   localparam int          LVL_W     = rtc_pkg::LVL_W;
   localparam int          GRP_W     = rtc_pkg::GRP_W;
   localparam int          GROUP_LSB = ROW_W - GRP_W;
   localparam int unsigned MAX_CYC   = rtc_pkg::to_cycles(rtc_pkg::TOP_TENTHS, CLK_PS);

   if (ROW_W < GRP_W) begin : g_bad_row
      $error("ROW_W must hold the row-group field");
   end
   if (NUM_MATS < 2) begin : g_bad_mats
      $error("NUM_MATS must be at least 2");
   end
   if (AGE_W < 1) begin : g_bad_age
      $error("AGE_W must be at least 1");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("CLK_PS must be nonzero");
   end
   if (MAX_CYC >= (64'd1 << CYC_W)) begin : g_bad_cyc
      $error("CYC_W too narrow for the longest pulse");
   end

   if (GROUP_LSB > 0) begin : g_low_bits
      logic unused_row_bits;
      assign unused_row_bits = ^wr_row[GROUP_LSB-1:0];
   end

   logic             prof_load;
   logic [LVL_W-1:0] prof_max;
   logic [LVL_W-1:0] wc_flag;
   logic             wr_accept;
   logic [CYC_W-1:0] look_cyc;

   rtc_profiler #(.NUM_MATS(NUM_MATS), .CODE_W(LVL_W)) u_prof (
      .clk(clk), .rst_n(rst_n), .start(prof_start), .valid(prof_valid),
      .code(prof_code), .load(prof_load), .max_code(prof_max));

   rtc_level_ager #(.LVL_W(LVL_W), .AGE_W(AGE_W)) u_age (
      .clk(clk), .rst_n(rst_n), .load(prof_load), .load_val(prof_max),
      .wr_accept(wr_accept), .level(wc_flag));

   rtc_lat_lookup #(.CLK_PS(CLK_PS), .CYC_W(CYC_W)) u_look (
      .level(wc_flag), .group(wr_row[ROW_W-1 -: GRP_W]), .cycles(look_cyc));

   rtc_pulse_timer #(.CYC_W(CYC_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .req(wr_req), .len(look_cyc),
      .accept(wr_accept), .busy(busy), .done(done), .len_q(pulse_cycles));
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker #(
   parameter int CYC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_req,
   input logic             busy,
   input logic             done,
   input logic [CYC_W-1:0] pulse_cycles,
   input logic [2:0]       wc_flag,
   input logic             prof_load
);
   a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy) |=> busy);
   a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pulse_cycles));
   a_r5_level_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prof_load) |-> (wc_flag >= $past(wc_flag)));
   a_r5_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prof_load) |-> ((wc_flag == $past(wc_flag)) || (wc_flag == $past(wc_flag) + 3'd1)));
   a_r6_level_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(prof_load) && $past(wc_flag) == 3'd7) |-> (wc_flag == 3'd7));
endmodule

bind reset_timing_ctrl rtc_checker #(.CYC_W(CYC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .busy(busy), .done(done),
   .pulse_cycles(pulse_cycles), .wc_flag(wc_flag), .prof_load(prof_load));

// File: tb/reset_timing_ctrl_test.sv
`timescale 1ns/1ps
module reset_timing_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prof_start = 1'b0;
   logic       prof_valid = 1'b0;
   logic [2:0] prof_code = '0;
   logic       wr_req = 1'b0;
   logic [8:0] wr_row = '0;
   logic       busy, done;
   logic [7:0] pulse_cycles;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   int tbl [8][8] = '{
      '{1097, 1069,  997,  908,  818,  732,  645,  564},
      '{1329, 1293, 1209, 1079,  939,  813,  692,  588},
      '{1546, 1509, 1409, 1260, 1079,  903,  747,  609},
      '{1738, 1697, 1585, 1420, 1219,  998,  802,  634},
      '{1890, 1843, 1726, 1548, 1329, 1090,  858,  655},
      '{1990, 1940, 1818, 1629, 1398, 1150,  905,  680},
      '{2024, 1977, 1849, 1659, 1423, 1172,  924,  691},
      '{2024, 1977, 1849, 1659, 1423, 1172,  924,  691}};

   always #4 clk = ~clk;

   reset_timing_ctrl uut (
      .clk(clk), .rst_n(rst_n), .prof_start(prof_start), .prof_valid(prof_valid),
      .prof_code(prof_code), .wr_req(wr_req), .wr_row(wr_row),
      .busy(busy), .done(done), .pulse_cycles(pulse_cycles));

   function automatic int exp_cyc(int lvl, int row);
      return (tbl[lvl][row / 64] * 100 + 7999) / 8000;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(int row, int lvl, string req, bit poke);
      int n = 0;
      int e = exp_cyc(lvl, row);
      @(negedge clk);
      wr_req = 1'b1;
      wr_row = row[8:0];
      @(negedge clk);
      wr_req = 1'b0;
      chk(busy && pulse_cycles == e, req, int'(pulse_cycles), e);
      while (busy && n < 400) begin
         n++;
         wr_req = (poke && n == 2);
         @(negedge clk);
      end
      wr_req = 1'b0;
      chk(n == e && done, req, n, e);
      @(negedge clk);
      chk(!done, req, int'(done), 0);
   endtask

   task automatic prof_begin();
      @(negedge clk);
      prof_start = 1'b1;
      @(negedge clk);
      prof_start = 1'b0;
   endtask

   task automatic prof_send(int m, int from, int upto);
      for (int i = from; i < upto; i++) begin
         prof_valid = 1'b1;
         prof_code = (i == (m * 7 + 3) % 64) ? m[2:0] : 3'((i * 5 + 3) % (m + 1));
         @(negedge clk);
      end
      prof_valid = 1'b0;
   endtask

   task automatic set_level(int m);
      prof_begin();
      prof_send(m, 0, 64);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && pulse_cycles == 0, "R1", int'(pulse_cycles), 0);
      do_write(0, 0, "R1", 0);
      do_write(511, 0, "R1", 0);

      // R2 / R4 sweep over all levels and groups
      for (int f = 0; f < 8; f++) begin
         set_level(f);
         for (int g = 0; g < 8; g++)
            do_write(g * 64 + (g * 13 + f) % 64, f, (g == 0) ? "R2" : "R4", 0);
      end

      // R3 write during pass uses old level; stray valid ignored
      set_level(5);
      prof_begin();
      prof_send(1, 0, 10);
      do_write(100, 5, "R3", 0);
      prof_send(1, 10, 64);
      do_write(70, 1, "R3", 0);
      @(negedge clk);
      prof_valid = 1'b1;
      prof_code = 3'd7;
      repeat (3) @(negedge clk);
      prof_valid = 1'b0;
      do_write(300, 1, "R3", 0);

      // R9 restart discards partial pass
      prof_begin();
      prof_send(7, 0, 21);
      prof_begin();
      prof_send(3, 0, 64);
      do_write(0, 3, "R9", 0);

      // R5 aging, wrapping write uses old level, reload clears counter
      set_level(2);
      for (int k = 0; k < 64; k++) do_write((k * 37) % 512, 2, "R5", 0);
      do_write(5, 3, "R5", 0);
      set_level(4);
      for (int k = 0; k < 64; k++) do_write((k * 29) % 512, 4, "R5", 0);
      do_write(200, 5, "R5", 0);

      // R6 saturation and last step into the top level
      set_level(7);
      for (int k = 0; k < 64; k++) do_write((k * 11) % 512, 7, "R6", 0);
      do_write(0, 7, "R6", 0);
      set_level(6);
      for (int k = 0; k < 64; k++) do_write((k * 19) % 512, 6, "R6", 0);
      do_write(64, 7, "R6", 0);

      // R8 requests during busy are ignored and not counted
      set_level(1);
      for (int k = 0; k < 64; k++) do_write((k * 23) % 512, 1, "R8", 1);
      do_write(448, 2, "R8", 0);

      // R7 shortest and longest pulses
      set_level(0);
      do_write(511, 0, "R7", 0);
      set_level(7);
      do_write(0, 7, "R7", 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule